// File: doc/BRIEF.md
# Phase-Shifted Fixed-Frequency Current Chopper

This block produces the switching pattern that holds the current in two stepper-motor windings at a target level. A free-running counter sets the chopping period. It issues a one-cycle period-start strobe for winding A, and the strobe for winding B arrives exactly half a period later. At its own period start, each channel turns on the low-side switch picked by the winding polarity from the step sequencer. After that the channel watches its current-sense comparator, which is already synchronized outside the block. The first trip seen after the blanking window turns the switch off. The switch then stays off until the next period start of that channel.

The chopping rate is fixed and comes from an internal counter, so the channels never run on a self-timed off-interval. The two channels are half a period apart, so their turn-on instants never coincide. The sequencer supplies, per channel, a polarity bit, an enable bit and a current-level code. A zero level or a low enable at the period start keeps that channel dark for the whole period. The analog reference (the input voltage divided by 4.9, scaled by the level) and the comparators themselves sit outside this block. A fault-kill input from the protection logic removes all four gate drives at once.

No data stream passes through the block. Every pin is a plain control or status level or strobe, with no valid/ready handshake and no back-pressure.

Top module: `chop_pwm_top`

## Requirements
- R1: While `rst_n` is low, all four gate outputs and both strobes are low.
- R2: `start_a` is a one-cycle pulse that recurs every `PERIOD_CYC` cycles. The first pulse comes `PERIOD_CYC` cycles after the cycle in which reset is released.
- R3: `start_b` pulses exactly `PERIOD_CYC/2` cycles after each `start_a` pulse.
- R4: If a channel is allowed at its period start, its selected gate is high from the cycle after the strobe. Without a trip, it stays high through the whole period.
- R5: The comparator is ignored during the first `BLANK_CYC` gate-on cycles, so a tripped period still has an on-time of `BLANK_CYC+1` cycles.
- R6: After blanking, a comparator level of 1 sampled at a clock edge turns the gate off from the next cycle on. The gate stays off until the channel's next period start, even when the comparator falls again.
- R7: If the channel enable is 0 or the level code is zero at the period start, both gates of that channel stay low for the whole period.
- R8: A polarity of 0 drives only the `_p` gate and a polarity of 1 drives only the `_n` gate. Polarity is latched at the period start, so a change in mid-period has no effect until the next start.
- R9: While `kill` is high, all four gates are low in that same cycle. A channel cut by `kill` stays off after `kill` falls, until its next period start.
- R10: A comparator trip sampled in the same cycle as the channel's period strobe is ignored. The new period begins with its blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_a | input | 1 | Synchronized current-sense trip, winding A |
| cmp_b | input | 1 | Synchronized current-sense trip, winding B |
| pol_a | input | 1 | Winding A polarity (0 selects `_p`, 1 selects `_n`) |
| pol_b | input | 1 | Winding B polarity (0 selects `_p`, 1 selects `_n`) |
| en_a | input | 1 | Winding A enable |
| en_b | input | 1 | Winding B enable |
| lvl_a | input | LVL_W | Winding A current-level code, zero means no current |
| lvl_b | input | LVL_W | Winding B current-level code, zero means no current |
| kill | input | 1 | Fault kill, forces all gates off |
| gate_ap | output | 1 | Gate enable, winding A positive switch |
| gate_an | output | 1 | Gate enable, winding A negative switch |
| gate_bp | output | 1 | Gate enable, winding B positive switch |
| gate_bn | output | 1 | Gate enable, winding B negative switch |
| start_a | output | 1 | Period-start strobe, winding A |
| start_b | output | 1 | Period-start strobe, winding B |

## Verification
A period start and a comparator trip can land in the same clock cycle. The start must win, and the new period must open with blanking instead of being cut at once. The bench provokes this by raising the comparator during the strobe cycle, and again inside and right at the edge of the blanking window. Each case is judged by the on-width that follows, counted in gate-high cycles: `BLANK_CYC+1` for every trip inside blanking, and exactly the trip offset for a trip after it. A fault kill that rises in mid-period is judged in its own cycle, and again after its release.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_BLANK = 2'd1,
    CH_ON    = 2'd2
  } ch_state_e;
endpackage

// File: rtl/chop_osc.sv
module chop_osc
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [NCH-1:0] start_o
);
  localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt <= '0;
    else if (cnt == CW'(PERIOD_CYC - 1)) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  // one registered strobe per channel, evenly spread over the period
  for (genvar g = 0; g < NCH; g++) begin : g_stb
    localparam int OFS = (g * PERIOD_CYC) / NCH;
    localparam int HIT = (OFS == 0) ? PERIOD_CYC - 1 : OFS - 1;
    logic stb_q;
    always_ff @(posedge clk) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= (cnt == CW'(HIT));
    end
    assign start_o[g] = stb_q;
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PERIOD_CYC - 1));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(PERIOD_CYC - 1)) |=> (cnt == '0));
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));
endmodule

// File: rtl/chop_chan.sv
module chop_chan
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 125,
  parameter int LVL_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             pol_i,
  input  logic             en_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             kill_i,
  output logic             gate_p_o,
  output logic             gate_n_o
);
  localparam int BW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC + 1) : 1;

  ch_state_e     state, state_n;
  logic [BW-1:0] bcnt, bcnt_n;
  logic          pol_q;
  logic          allowed;
  logic          drive;

  assign allowed = en_i && (lvl_i != '0);

  always_comb begin
    state_n = state;
    bcnt_n  = bcnt;
    if (kill_i) begin
      state_n = CH_OFF;
    end else if (start_i) begin
      // a new period overrides any trip seen in the same cycle
      state_n = allowed ? CH_BLANK : CH_OFF;
      bcnt_n  = '0;
    end else begin
      unique case (state)
        CH_BLANK: begin
          if (bcnt == BW'(BLANK_CYC - 1)) state_n = CH_ON;
          else                            bcnt_n  = bcnt + 1'b1;
        end
        CH_ON:   if (cmp_i) state_n = CH_OFF;
        default: state_n = CH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CH_OFF;
      bcnt  <= '0;
      pol_q <= 1'b0;
    end else begin
      state <= state_n;
      bcnt  <= bcnt_n;
      if (start_i) pol_q <= pol_i;
    end
  end

  assign drive    = (state != CH_OFF) && !kill_i;
  assign gate_p_o = drive && !pol_q;
  assign gate_n_o = drive &&  pol_q;

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_p_o && gate_n_o));
  a_r8_pol_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(pol_q));
  a_r6_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_OFF && !start_i) |=> (state == CH_OFF));
  a_r5_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_BLANK && !start_i && !kill_i) |=> (state != CH_OFF));
  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && allowed && !kill_i) |=> (state == CH_BLANK && bcnt == '0));
  a_r9_kill_latches: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (state == CH_OFF));
endmodule

// File: rtl/chop_pwm_top.sv
module chop_pwm_top
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 125,
  parameter int LVL_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_a,
  input  logic             cmp_b,
  input  logic             pol_a,
  input  logic             pol_b,
  input  logic             en_a,
  input  logic             en_b,
  input  logic [LVL_W-1:0] lvl_a,
  input  logic [LVL_W-1:0] lvl_b,
  input  logic             kill,
  output logic             gate_ap,
  output logic             gate_an,
  output logic             gate_bp,
  output logic             gate_bn,
  output logic             start_a,
  output logic             start_b
);
  logic [NCH-1:0] stb, cmp_v, pol_v, en_v, gp_v, gn_v;
  logic [LVL_W-1:0] lvl_v [NCH];

  assign cmp_v    = {cmp_b, cmp_a};
  assign pol_v    = {pol_b, pol_a};
  assign en_v     = {en_b, en_a};
  assign lvl_v[0] = lvl_a;
  assign lvl_v[1] = lvl_b;

  chop_osc #(.PERIOD_CYC(PERIOD_CYC)) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_o (stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chop_chan #(.BLANK_CYC(BLANK_CYC), .LVL_W(LVL_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (stb[c]),
      .cmp_i    (cmp_v[c]),
      .pol_i    (pol_v[c]),
      .en_i     (en_v[c]),
      .lvl_i    (lvl_v[c]),
      .kill_i   (kill),
      .gate_p_o (gp_v[c]),
      .gate_n_o (gn_v[c])
    );
  end

  assign gate_ap = gp_v[0];
  assign gate_an = gn_v[0];
  assign gate_bp = gp_v[1];
  assign gate_bn = gn_v[1];
  assign start_a = stb[0];
  assign start_b = stb[1];

  a_r9_kill_dark: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !(gate_ap || gate_an || gate_bp || gate_bn));
  a_r3_apart: assert property (@(posedge clk) disable iff (!rst_n)
    start_a |-> !start_b);
endmodule

// File: tb/test_chop_pwm_top.sv
module test_chop_pwm_top;
  localparam int P  = 40;
  localparam int B  = 6;
  localparam int LW = 4;
  localparam int H  = P / 2;
  localparam int NV = 10;

  typedef struct packed {
    logic          pol;
    logic          en;
    logic [LW-1:0] lvl;
    logic [7:0]    trip;
    logic [7:0]    expw;
  } vec_t;

  // trip = cycle offset after the strobe where the comparator rises (40 = none)
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 4'd8,  8'd40, 8'd40},  // R4 full period
    '{1'b0, 1'b1, 4'd8,  8'd15, 8'd15},  // R6 trip after blanking
    '{1'b1, 1'b1, 4'd3,  8'd10, 8'd10},  // R8 negative side
    '{1'b1, 1'b1, 4'd15, 8'd3,  8'd7},   // R5 trip inside blanking
    '{1'b0, 1'b1, 4'd1,  8'd0,  8'd7},   // R10 trip with strobe
    '{1'b0, 1'b0, 4'd8,  8'd40, 8'd0},   // R7 enable low
    '{1'b1, 1'b1, 4'd0,  8'd40, 8'd0},   // R7 zero level
    '{1'b0, 1'b1, 4'd8,  8'd7,  8'd7},   // R5 first sampled cycle
    '{1'b1, 1'b1, 4'd2,  8'd6,  8'd7},   // R5 last blanked cycle
    '{1'b1, 1'b1, 4'd4,  8'd39, 8'd39}   // R6 late trip
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmp_a, cmp_b, pol_a, pol_b, en_a, en_b, kill;
  logic [LW-1:0] lvl_a, lvl_b;
  logic gate_ap, gate_an, gate_bp, gate_bn, start_a, start_b;

  chop_pwm_top #(.PERIOD_CYC(P), .BLANK_CYC(B), .LVL_W(LW)) i_chop_pwm_top (
    .clk(clk), .rst_n(rst_n), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .pol_a(pol_a), .pol_b(pol_b), .en_a(en_a), .en_b(en_b),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .kill(kill),
    .gate_ap(gate_ap), .gate_an(gate_an), .gate_bp(gate_bp), .gate_bn(gate_bn),
    .start_a(start_a), .start_b(start_b)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_a(input logic p, input logic e, input logic [LW-1:0] l, input int trip);
    pol_a = p; en_a = e; lvl_a = l; cmp_a = (trip == 0);
  endtask

  // runs the cycles c+1 .. c+P after an A strobe seen in cycle c
  task automatic run_period(input int trip, input int kill_on, input int kill_off,
                            input int flip_at, output int np, output int nn,
                            output int leak, output int sb_k, output int sa_end,
                            output int bn_cnt, output int bn_first);
    np = 0; nn = 0; leak = 0; sb_k = -1; sa_end = 0; bn_cnt = 0; bn_first = -1;
    for (int k = 1; k <= P; k++) begin
      @(negedge clk);
      if (k == kill_on)  kill = 1'b1;
      if (k == kill_off) kill = 1'b0;
      if (k == flip_at)  pol_a = ~pol_a;
      cmp_a = (k >= trip);
      #1;
      if (gate_ap) np++;
      if (gate_an) nn++;
      if (kill && (gate_ap || gate_an || gate_bp || gate_bn)) leak++;
      if (start_b) sb_k = k;
      if (k == P) sa_end = int'(start_a);
      if (gate_bn) begin
        bn_cnt++;
        if (bn_first < 0) bn_first = k;
      end
    end
  endtask

  initial begin
    int np, nn, leak, sbk, sae, bnc, bnf, k;
    rst_n = 1'b0; kill = 1'b0;
    cmp_a = 1'b0; cmp_b = 1'b0; pol_a = 1'b0; pol_b = 1'b0;
    en_a = 1'b1; en_b = 1'b0; lvl_a = 4'd5; lvl_b = 4'd0;
    repeat (3) @(negedge clk);
    #1;
    // R1: everything quiet in reset even with channel A requested
    check("R1 outputs in reset",
          int'(gate_ap) + int'(gate_an) + int'(gate_bp) + int'(gate_bn) +
          int'(start_a) + int'(start_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    do begin
      @(negedge clk); #1; k++;
    end while (!start_a && k < 3 * P);
    check("R2 first strobe delay", k, P);

    for (int r = 0; r < NV; r++) begin
      apply_a(TBL[r].pol, TBL[r].en, TBL[r].lvl, int'(TBL[r].trip));
      run_period(int'(TBL[r].trip), -1, -1, -1, np, nn, leak, sbk, sae, bnc, bnf);
      if (TBL[r].pol) begin
        check("R4 R5 R6 R7 R10 on-width", nn, int'(TBL[r].expw));
        check("R8 unselected side", np, 0);
      end else begin
        check("R4 R5 R6 R7 R10 on-width", np, int'(TBL[r].expw));
        check("R8 unselected side", nn, 0);
      end
      check("R3 B strobe offset", sbk, H);
      check("R2 strobe period", sae, 1);
    end

    // R8: mid-period polarity change waits for the next start
    apply_a(1'b0, 1'b1, 4'd5, 99);
    run_period(99, -1, -1, 3, np, nn, leak, sbk, sae, bnc, bnf);
    check("R8 pol held p", np, P);
    check("R8 pol held n", nn, 0);
    run_period(99, -1, -1, -1, np, nn, leak, sbk, sae, bnc, bnf);
    check("R8 pol applied n", nn, P);
    check("R8 pol applied p", np, 0);

    // R9: kill cuts at once and the channel stays off after release
    apply_a(1'b0, 1'b1, 4'd5, 99);
    run_period(99, 5, 8, -1, np, nn, leak, sbk, sae, bnc, bnf);
    check("R9 on before kill", np, 4);
    check("R9 gates during kill", leak, 0);
    run_period(99, -1, -1, -1, np, nn, leak, sbk, sae, bnc, bnf);
    check("R9 recovery next period", np, P);

    // R3 R4: channel B starts half a period later
    en_b = 1'b1; pol_b = 1'b1; lvl_b = 4'd3; cmp_b = 1'b0;
    run_period(99, -1, -1, -1, np, nn, leak, sbk, sae, bnc, bnf);
    check("R3 B first on cycle", bnf, H + 1);
    check("R4 B on-width", bnc, H);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule